// File: doc/BRIEF.md
# Float-to-integer conversion unit

The unit takes one binary32 floating-point operand and turns it into a 64-bit integer result. The caller picks the integer target, signed or unsigned and 32 or 64 bits wide, along with a rounding mode, a conversion mode and an overflow-enable bit. The conversion mode sets the policy for NaNs and for values the target type cannot hold. The two saturating policies clamp to the type limits and differ only in how they treat NaN. The wrap policy truncates toward zero and keeps the low bits of the exact two's-complement integer.

The unit is a two-stage pipeline. The first stage unpacks the operand, aligns the significand and rounds it to an integer magnitude. The intermediate is 128 bits wide, so it is exact for every finite binary32 value. The second stage checks the range, applies the policy, extends 32-bit results and derives the status flags. A new operand can enter on every cycle, and the result with all its flags appears two cycles later, qualified by a valid output.

Top module: `f2i_convert`

## Requirements
- R1: `itype_i` selects the target: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. Bit 0 set means unsigned and bit 1 set means 64-bit. An in-range signed 32-bit result is sign-extended from bit 31 to 64 bits. An unsigned 32-bit result is zero-extended.
- R2: With `cmode_i[2]`=0, `rmode_i` selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: When `cmode_i[2]`=1, rounding is toward zero whatever `rmode_i` holds.
- R4: In conversion modes 0 and 1, a NaN operand yields the most negative value of the target type: 0xFFFFFFFF80000000 for signed 32-bit, 0x8000000000000000 for signed 64-bit, and 0 for the unsigned types.
- R5: In conversion modes 0 to 3, a rounded value above the type maximum (including +infinity) yields the maximum. A value below the type minimum (including -infinity, and any negative nonzero value for unsigned types) yields the minimum.
- R6: In conversion modes 2 and 3, a NaN operand yields 0.
- R7: In conversion modes 4 and 5, infinity and NaN yield 0. Any other operand yields the low 32 or 64 bits of the exact two's-complement integer, extended as in R1.
- R8: `inv_o` is set when the operand is NaN or the delivered result differs in value from the rounded operand. `inexact_o` and `frac_rnd_o` are then 0.
- R9: When `inv_o` is clear, `inexact_o` is set if the result differs from the operand. `frac_rnd_o` is set if the result's magnitude exceeds the operand's magnitude.
- R10: `ovf_o` equals the invalid condition of R8 when `ovf_en_i` is 1, and is 0 when `ovf_en_i` is 0.
- R11: `snan_o` is set for a signalling NaN (exponent all ones, nonzero fraction, fraction bit 22 clear), together with `inv_o`. A quiet NaN leaves `snan_o` clear.
- R12: Conversion modes 6 and 7 are illegal. They give result 0 with `illegal_o` set, and `inv_o`, `ovf_o`, `inexact_o`, `frac_rnd_o` and `snan_o` clear.
- R13: A result with its flags appears with `valid_o` high exactly two cycles after the operand is presented with `valid_i`. Back-to-back operands are accepted on consecutive cycles, and reset clears `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| op_i | input | 32 | binary32 operand |
| itype_i | input | 2 | Integer target type |
| rmode_i | input | 2 | Rounding mode |
| cmode_i | input | 3 | Conversion (overflow/NaN policy) mode |
| ovf_en_i | input | 1 | Enables the overflow output |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Integer result |
| ovf_o | output | 1 | Overflow, gated by the enable |
| inv_o | output | 1 | Invalid conversion |
| inexact_o | output | 1 | Result differs from operand |
| frac_rnd_o | output | 1 | Magnitude rounded upward |
| snan_o | output | 1 | Signalling-NaN operand |
| illegal_o | output | 1 | Illegal conversion mode |

## Verification
The directed cases cover ties, for example 2.5, which rounds to 2 under nearest-even. A design that rounds half away from zero would return 3 and raise the fraction-rounded flag. Rounding of a negative value can give -0, as with -0.5 converted to unsigned. A design that treats the sign bit alone as "below minimum" would wrongly flag this as invalid. Values at and just beyond ±2^63 and 2^100 test the 128-bit intermediate: a narrow intermediate would lose the wrapped low bits or mis-saturate. NaN under each policy and type, signalling versus quiet NaN, subnormals under directed rounding, the overflow-enable gate, the forced-truncation bit, the illegal modes, and back-to-back issue complete the set; each exposes a swapped or dropped case in the policy mux or in the flag gating.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  parameter int FW = 32;  // source float width
  parameter int EW = 8;   // exponent bits
  parameter int MW = 23;  // stored fraction bits
  parameter int IW = 128; // exact integer intermediate width
  parameter int OW = 64;  // result width

  typedef enum logic [1:0] {
    IT_S32 = 2'd0,
    IT_U32 = 2'd1,
    IT_S64 = 2'd2,
    IT_U64 = 2'd3
  } itype_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic          sign;
    logic [IW-1:0] mag;
    logic          nan;
    logic          snan;
    logic          inf;
    logic          inexact;
    logic          inc;
    itype_e        itype;
    logic [2:0]    cmode;
    logic          ovf_en;
  } stage1_t;
endpackage

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic [FW-1:0] op_i,
  input  logic [1:0]    rmode_i,
  input  logic          force_trunc_i,
  output logic          sign_o,
  output logic [IW-1:0] mag_o,
  output logic          nan_o,
  output logic          snan_o,
  output logic          inf_o,
  output logic          inexact_o,
  output logic          inc_o
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SH0  = BIAS + MW;      // exponent at which the lsb weighs 1
  localparam int RB   = MW + 3;         // right-shift cap, keeps every bit
  localparam int XW   = MW + 1 + RB;

  logic [EW-1:0] exp_w, eeff_w, lsh_w, rsh_w, rsh_cap_w;
  logic [MW-1:0] frac_w;
  logic [MW:0]   mant_w, ipart_w;
  logic [XW-1:0] x_w;
  logic          big_w, rbit_w, sticky_w, lost_w;
  rmode_e        rm_w;

  assign sign_o = op_i[FW-1];
  assign exp_w  = op_i[FW-2:MW];
  assign frac_w = op_i[MW-1:0];
  assign mant_w = {exp_w != '0, frac_w};
  assign eeff_w = (exp_w == '0) ? EW'(1) : exp_w;

  assign nan_o  = (exp_w == '1) && (frac_w != '0);
  assign snan_o = nan_o && !frac_w[MW-1];
  assign inf_o  = (exp_w == '1) && (frac_w == '0);

  assign big_w     = eeff_w >= EW'(SH0);
  assign lsh_w     = eeff_w - EW'(SH0);
  assign rsh_w     = EW'(SH0) - eeff_w;
  assign rsh_cap_w = (rsh_w > EW'(RB)) ? EW'(RB) : rsh_w;

  assign x_w      = {mant_w, {RB{1'b0}}} >> rsh_cap_w;
  assign ipart_w  = x_w[XW-1:RB];
  assign rbit_w   = x_w[RB-1];
  assign sticky_w = |x_w[RB-2:0];
  assign lost_w   = rbit_w | sticky_w;

  assign rm_w = force_trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  always_comb begin
    inc_o     = 1'b0;
    inexact_o = 1'b0;
    mag_o     = '0;
    if (!(nan_o || inf_o)) begin
      if (big_w) begin
        mag_o = IW'(mant_w) << lsh_w;
      end else begin
        inexact_o = lost_w;
        unique case (rm_w)
          RM_NEAR: inc_o = rbit_w & (sticky_w | ipart_w[0]);
          RM_UP:   inc_o = lost_w & !sign_o;
          RM_DOWN: inc_o = lost_w & sign_o;
          default: inc_o = 1'b0;
        endcase
        mag_o = IW'(ipart_w) + IW'(inc_o);
      end
    end
  end
endmodule

// File: rtl/fcvt_range.sv
module fcvt_range
  import fcvt_pkg::*;
(
  input  stage1_t       s1_i,
  output logic [OW-1:0] result_o,
  output logic          inv_o,
  output logic          inexact_o,
  output logic          frac_rnd_o,
  output logic          snan_o,
  output logic          illegal_o
);
  localparam int NW = OW / 2;

  logic          is64_w, uns_w, over_w, under_w, oor_w, legal_w;
  logic [IW-1:0] max_mag_w, min_mag_w, neg_min_w, val_w;
  logic [OW-1:0] max_val_w, min_val_w, raw_w, ext_w;
  int unsigned   w_w;

  assign is64_w = s1_i.itype[1];
  assign uns_w  = s1_i.itype[0];
  assign w_w    = is64_w ? OW : NW;

  assign max_mag_w = uns_w ? ((IW'(1) << w_w) - IW'(1)) : ((IW'(1) << (w_w - 1)) - IW'(1));
  assign min_mag_w = uns_w ? '0 : (IW'(1) << (w_w - 1));
  assign neg_min_w = '0 - min_mag_w;
  assign max_val_w = max_mag_w[OW-1:0];
  assign min_val_w = neg_min_w[OW-1:0];

  assign over_w  = !s1_i.sign && (s1_i.inf || (s1_i.mag > max_mag_w));
  assign under_w = s1_i.sign && (s1_i.inf || (s1_i.mag > min_mag_w));
  assign oor_w   = over_w || under_w;

  assign val_w = s1_i.sign ? ('0 - s1_i.mag) : s1_i.mag;

  assign illegal_o = s1_i.cmode[2] && s1_i.cmode[1];
  assign legal_w   = !illegal_o;

  always_comb begin
    if (s1_i.cmode[2]) begin
      raw_w = (s1_i.nan || s1_i.inf) ? '0 : val_w[OW-1:0];
    end else if (s1_i.nan) begin
      raw_w = s1_i.cmode[1] ? '0 : min_val_w;
    end else if (over_w) begin
      raw_w = max_val_w;
    end else if (under_w) begin
      raw_w = min_val_w;
    end else begin
      raw_w = val_w[OW-1:0];
    end
  end

  always_comb begin
    if (is64_w)     ext_w = raw_w;
    else if (uns_w) ext_w = {{(OW-NW){1'b0}}, raw_w[NW-1:0]};
    else            ext_w = {{(OW-NW){raw_w[NW-1]}}, raw_w[NW-1:0]};
  end

  assign result_o   = legal_w ? ext_w : '0;
  assign inv_o      = legal_w && (s1_i.nan || oor_w);
  assign inexact_o  = legal_w && !inv_o && s1_i.inexact;
  assign frac_rnd_o = legal_w && !inv_o && s1_i.inc;
  assign snan_o     = legal_w && s1_i.snan;
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import fcvt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [31:0]   op_i,
  input  logic [1:0]    itype_i,
  input  logic [1:0]    rmode_i,
  input  logic [2:0]    cmode_i,
  input  logic          ovf_en_i,
  output logic          valid_o,
  output logic [63:0]   result_o,
  output logic          ovf_o,
  output logic          inv_o,
  output logic          inexact_o,
  output logic          frac_rnd_o,
  output logic          snan_o,
  output logic          illegal_o
);
  localparam int NW = OW / 2;

  stage1_t       s1_d, s1_q;
  logic          s1_valid_q;
  logic [OW-1:0] res_d;
  logic          inv_d, inx_d, frac_d, snan_d, ill_d;

  // stage 1: unpack and round
  fcvt_round u_round (
    .op_i         (op_i),
    .rmode_i      (rmode_i),
    .force_trunc_i(cmode_i[2]),
    .sign_o       (s1_d.sign),
    .mag_o        (s1_d.mag),
    .nan_o        (s1_d.nan),
    .snan_o       (s1_d.snan),
    .inf_o        (s1_d.inf),
    .inexact_o    (s1_d.inexact),
    .inc_o        (s1_d.inc)
  );
  assign s1_d.itype  = itype_e'(itype_i);
  assign s1_d.cmode  = cmode_i;
  assign s1_d.ovf_en = ovf_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_q       <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) s1_q <= s1_d;
    end
  end

  // stage 2: range, policy, extension, flags
  fcvt_range u_range (
    .s1_i      (s1_q),
    .result_o  (res_d),
    .inv_o     (inv_d),
    .inexact_o (inx_d),
    .frac_rnd_o(frac_d),
    .snan_o    (snan_d),
    .illegal_o (ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      ovf_o      <= 1'b0;
      inv_o      <= 1'b0;
      inexact_o  <= 1'b0;
      frac_rnd_o <= 1'b0;
      snan_o     <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        result_o   <= res_d;
        ovf_o      <= inv_d && s1_q.ovf_en;
        inv_o      <= inv_d;
        inexact_o  <= inx_d;
        frac_rnd_o <= frac_d;
        snan_o     <= snan_d;
        illegal_o  <= ill_d;
      end
    end
  end

  // R1
  u32_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(s1_q.itype) == IT_U32 |-> result_o[OW-1:NW] == '0);
  // R8
  inv_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && inv_o |-> !inexact_o && !frac_rnd_o);
  // R9
  frac_needs_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && frac_rnd_o |-> inexact_o);
  // R10
  ovf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ovf_o |-> inv_o && $past(s1_q.ovf_en));
  // R11
  snan_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && snan_o |-> inv_o);
  // R12
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> result_o == '0 && !inv_o && !ovf_o && !snan_o);
  // R13
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_valid_q));
endmodule

// File: tb/tb_f2i_convert.sv
`timescale 1ns/1ps
module tb_f2i_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [1:0]  itype_i = '0, rmode_i = '0;
  logic [2:0]  cmode_i = '0;
  logic        ovf_en_i = 1'b0;
  logic        valid_o, ovf_o, inv_o, inexact_o, frac_rnd_o, snan_o, illegal_o;
  logic [63:0] result_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  f2i_convert dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .itype_i(itype_i), .rmode_i(rmode_i), .cmode_i(cmode_i), .ovf_en_i(ovf_en_i),
    .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o), .inv_o(inv_o),
    .inexact_o(inexact_o), .frac_rnd_o(frac_rnd_o), .snan_o(snan_o), .illegal_o(illegal_o)
  );

  // flags order: inv ovf inexact frac snan illegal
  function automatic logic [5:0] flags();
    return {inv_o, ovf_o, inexact_o, frac_rnd_o, snan_o, illegal_o};
  endfunction

  task automatic check(input string req, input logic v, input logic [63:0] er, input logic [5:0] ef);
    n_chk++;
    if (valid_o !== v || result_o !== er || flags() !== ef) begin
      n_bad++;
      $display("FAIL %s: valid=%0b result=%h flags=%b expected valid=%0b result=%h flags=%b",
               req, valid_o, result_o, flags(), v, er, ef);
    end
  endtask

  task automatic conv(input string req, input logic [31:0] op, input logic [1:0] it,
                      input logic [1:0] rm, input logic [2:0] cm, input logic oe,
                      input logic [63:0] er, input logic [5:0] ef);
    @(negedge clk);
    valid_i = 1; op_i = op; itype_i = it; rmode_i = rm; cmode_i = cm; ovf_en_i = oe;
    @(negedge clk);
    valid_i = 0;
    @(negedge clk);
    check(req, 1'b1, er, ef);
  endtask

  task automatic t_reset();
    check("R13 reset", 1'b0, 64'h0, 6'b000000);
  endtask

  task automatic t_round();
    conv("R2 near 1.5",   32'h3FC00000, 2'd0, 2'b00, 3'd0, 1, 64'd2, 6'b001100);
    conv("R2 near tie 2.5", 32'h40200000, 2'd0, 2'b00, 3'd0, 1, 64'd2, 6'b001000);
    conv("R2 up 2.5",     32'h40200000, 2'd0, 2'b10, 3'd0, 1, 64'd3, 6'b001100);
    conv("R2 down -2.5",  32'hC0200000, 2'd0, 2'b11, 3'd0, 1, 64'hFFFFFFFFFFFFFFFD, 6'b001100);
    conv("R2 zero 2.5",   32'h40200000, 2'd0, 2'b01, 3'd0, 1, 64'd2, 6'b001000);
    conv("R2 up -2.5",    32'hC0200000, 2'd0, 2'b10, 3'd0, 1, 64'hFFFFFFFFFFFFFFFE, 6'b001000);
  endtask

  task automatic t_trunc();
    conv("R3 forced over up",   32'h40200000, 2'd0, 2'b10, 3'd4, 1, 64'd2, 6'b001000);
    conv("R3 forced over down", 32'hC0200000, 2'd0, 2'b11, 3'd5, 1, 64'hFFFFFFFFFFFFFFFE, 6'b001000);
  endtask

  task automatic t_types();
    conv("R1 s32 -2",   32'hC0000000, 2'd0, 2'b00, 3'd0, 1, 64'hFFFFFFFFFFFFFFFE, 6'b000000);
    conv("R1 u32 3e9",  32'h4F32D05E, 2'd1, 2'b00, 3'd0, 1, 64'h00000000B2D05E00, 6'b000000);
    conv("R1 s64 -2^63", 32'hDF000000, 2'd2, 2'b00, 3'd0, 1, 64'h8000000000000000, 6'b000000);
    conv("R1 u64 2^63", 32'h5F000000, 2'd3, 2'b00, 3'd0, 1, 64'h8000000000000000, 6'b000000);
  endtask

  task automatic t_nan_min();
    conv("R4 nan s32", 32'h7FC00000, 2'd0, 2'b00, 3'd0, 1, 64'hFFFFFFFF80000000, 6'b110000);
    conv("R4 nan u32", 32'h7FC00000, 2'd1, 2'b00, 3'd1, 1, 64'h0, 6'b110000);
    conv("R4 nan s64", 32'h7FC00000, 2'd2, 2'b00, 3'd0, 1, 64'h8000000000000000, 6'b110000);
    conv("R4 nan u64", 32'hFFC00000, 2'd3, 2'b00, 3'd1, 1, 64'h0, 6'b110000);
  endtask

  task automatic t_nan_zero();
    conv("R6 nan s32 m2", 32'h7FC00000, 2'd0, 2'b00, 3'd2, 1, 64'h0, 6'b110000);
    conv("R6 nan s64 m3", 32'h7FC00000, 2'd2, 2'b00, 3'd3, 1, 64'h0, 6'b110000);
  endtask

  task automatic t_sat();
    conv("R5 3e9 s32",    32'h4F32D05E, 2'd0, 2'b00, 3'd0, 1, 64'h000000007FFFFFFF, 6'b110000);
    conv("R5 +inf s64",   32'h7F800000, 2'd2, 2'b00, 3'd2, 1, 64'h7FFFFFFFFFFFFFFF, 6'b110000);
    conv("R5 -inf s32",   32'hFF800000, 2'd0, 2'b00, 3'd2, 1, 64'hFFFFFFFF80000000, 6'b110000);
    conv("R5 -1 u32",     32'hBF800000, 2'd1, 2'b00, 3'd0, 1, 64'h0, 6'b110000);
    conv("R5 2^63 s64",   32'h5F000000, 2'd2, 2'b00, 3'd1, 1, 64'h7FFFFFFFFFFFFFFF, 6'b110000);
    conv("R5 -0.5 dn u32", 32'hBF000000, 2'd1, 2'b11, 3'd0, 1, 64'h0, 6'b110000);
  endtask

  task automatic t_wrap();
    conv("R7 3e9 s32",   32'h4F32D05E, 2'd0, 2'b00, 3'd4, 1, 64'hFFFFFFFFB2D05E00, 6'b110000);
    conv("R7 -1 u32",    32'hBF800000, 2'd1, 2'b00, 3'd4, 1, 64'h00000000FFFFFFFF, 6'b110000);
    conv("R7 -1 u64",    32'hBF800000, 2'd3, 2'b00, 3'd5, 1, 64'hFFFFFFFFFFFFFFFF, 6'b110000);
    conv("R7 2^100 u64", 32'h71800000, 2'd3, 2'b00, 3'd4, 1, 64'h0, 6'b110000);
    conv("R7 inf",       32'h7F800000, 2'd2, 2'b00, 3'd4, 1, 64'h0, 6'b110000);
    conv("R7 nan",       32'h7FC00000, 2'd0, 2'b00, 3'd5, 1, 64'h0, 6'b110000);
    conv("R7 1.5 s64",   32'h3FC00000, 2'd2, 2'b00, 3'd4, 1, 64'd1, 6'b001000);
  endtask

  task automatic t_flags();
    conv("R9 denorm up",   32'h00000001, 2'd0, 2'b10, 3'd0, 1, 64'd1, 6'b001100);
    conv("R9 denorm down", 32'h00000001, 2'd0, 2'b11, 3'd0, 1, 64'd0, 6'b001000);
    conv("R8 -0.5 u32 no inv", 32'hBF000000, 2'd1, 2'b00, 3'd0, 1, 64'd0, 6'b001000);
    conv("R9 -denorm near", 32'h80000001, 2'd2, 2'b00, 3'd2, 1, 64'd0, 6'b001000);
  endtask

  task automatic t_ovf_gate();
    conv("R10 ovf off", 32'h4F32D05E, 2'd0, 2'b00, 3'd0, 0, 64'h000000007FFFFFFF, 6'b100000);
    conv("R10 nan ovf off", 32'h7FC00000, 2'd0, 2'b00, 3'd2, 0, 64'h0, 6'b100000);
  endtask

  task automatic t_snan();
    conv("R11 snan", 32'h7F800001, 2'd0, 2'b00, 3'd0, 0, 64'hFFFFFFFF80000000, 6'b100010);
    conv("R11 -snan m2", 32'hFFA00000, 2'd3, 2'b00, 3'd2, 1, 64'h0, 6'b110010);
  endtask

  task automatic t_illegal();
    conv("R12 mode6", 32'h3FC00000, 2'd0, 2'b00, 3'd6, 1, 64'h0, 6'b000001);
    conv("R12 mode7 snan", 32'h7F800001, 2'd2, 2'b00, 3'd7, 1, 64'h0, 6'b000001);
  endtask

  task automatic t_pipe();
    @(negedge clk);
    valid_i = 1; op_i = 32'h3F800000; itype_i = 2'd0; rmode_i = 2'b00; cmode_i = 3'd0; ovf_en_i = 1;
    @(negedge clk);
    op_i = 32'h40000000;
    @(negedge clk);
    valid_i = 0;
    check("R13 pipe first", 1'b1, 64'd1, 6'b000000);
    @(negedge clk);
    check("R13 pipe second", 1'b1, 64'd2, 6'b000000);
    @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 pipe drain: valid=%0b expected valid=0", valid_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round();
    t_trunc();
    t_types();
    t_nan_min();
    t_nan_zero();
    t_sat();
    t_wrap();
    t_flags();
    t_ovf_gate();
    t_snan();
    t_illegal();
    t_pipe();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R13 watchdog: finished=0 expected finished=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule